// File: doc/BRIEF.md
# Adaptive Per-Port Buffer Admission Controller

This block keeps a running count of the 128-byte packet buffers held by each of three ingress ports. On every allocate request it decides at once whether the port may take one more buffer (grant) or must be refused (drop). It also raises a per-port pause request that tells the link partner to hold off, by pause frame or backpressure. The limits adapt to load. A port counts as busy once it holds a fixed number of buffers. While at most one port is busy, a generous pair of limits applies. Once two or more ports are busy, a stricter pair takes over.

Two 32-bit configuration words, written and read through a simple register port, hold the limits. One word holds the drop limits and the other holds the pause thresholds. In each word the stricter (crowded) value sits in bits 15:8 and the generous (single-port) value sits in bits 7:0. The busy count and the selected limits are derived combinationally from the counters as registered at the start of each cycle. An allocation granted in one cycle therefore affects the limits only from the next cycle on.

Top module: `buf_admit_ctrl`

## Requirements
- R1: Each port's count rises by one when an allocate is granted and falls by one on a free. It stays unchanged when a granted allocate and a free of the same port coincide.
- R2: A port is busy when its count is at least 36. With zero or one port busy, the limits in bits 7:0 of each word apply to every port. With two or three busy, the limits in bits 15:8 apply. The decision uses the counts registered at the start of the cycle.
- R3: In the cycle of an allocate request, the request is refused with a drop pulse if the port's count is at or above the current drop limit. Otherwise it is granted and the count increments at the next edge. Grant and drop never rise without a request, and never both at once.
- R4: A port's pause output is high exactly while its count is at or above the current pause threshold.
- R5: Register address 0 selects the drop word and address 1 selects the pause word. A write stores bits 15:8 (crowded limit) and 7:0 (single-port limit). Bits 31:16 read as zero whatever was written, and a write to one word leaves the other untouched.
- R6: Synchronous reset clears every count and loads the drop word with 0x49 in bits 15:8 and 0x64 in bits 7:0, and the pause word with 0x21 and 0x3C.
- R7: A free at count zero is ignored. A count never exceeds 255 and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | NUM_PORTS | Per-port request for one buffer |
| free_req | input | NUM_PORTS | Per-port release of one buffer |
| alloc_grant | output | NUM_PORTS | Request accepted this cycle |
| alloc_drop | output | NUM_PORTS | Request refused this cycle |
| pause_req | output | NUM_PORTS | Ask the link partner to stop sending |
| cfg_wr_en | input | 1 | Write strobe for the addressed word |
| cfg_addr | input | 1 | 0 = drop word, 1 = pause word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word |

## Verification
The bench uses the default parameters: three ports, 8-bit counts and a busy threshold of 36. With these values, one port can be filled past the single-port limits, and a second port can then cross the threshold to force the crowded limits within a few hundred cycles. Reprogramming both words to 0xFFFF brings the 255 saturation point within reach. Programming a pause word whose single-port threshold is below its crowded one shows that the idle case uses the single-port set.

// File: rtl/buf_adm_pkg.sv
package buf_adm_pkg;

    localparam int LVL_W  = 8;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [LVL_W-1:0] crowded;
        logic [LVL_W-1:0] single;
    } lvl_pair_t;

    typedef enum logic {
        CFG_DROP  = 1'b0,
        CFG_PAUSE = 1'b1
    } cfg_sel_e;

    localparam lvl_pair_t DROP_RST  = '{crowded: 8'h49, single: 8'h64};
    localparam lvl_pair_t PAUSE_RST = '{crowded: 8'h21, single: 8'h3C};

    function automatic logic [LVL_W-1:0] pick_level(lvl_pair_t p, logic busy_many);
        return busy_many ? p.crowded : p.single;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(lvl_pair_t p);
        return {{(WORD_W-2*LVL_W){1'b0}}, p};
    endfunction

    function automatic lvl_pair_t unpack_word(logic [WORD_W-1:0] w);
        return lvl_pair_t'(w[2*LVL_W-1:0]);
    endfunction

endpackage

// File: rtl/adm_cfg_regs.sv
module adm_cfg_regs
    import buf_adm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [WORD_W-1:0] wdata,
    output lvl_pair_t         drop_lvl,
    output lvl_pair_t         pause_lvl,
    output logic [WORD_W-1:0] rdata
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            drop_lvl  <= DROP_RST;
            pause_lvl <= PAUSE_RST;
        end else if (wr_en) begin
            if (sel == CFG_DROP) drop_lvl  <= unpack_word(wdata);
            else                 pause_lvl <= unpack_word(wdata);
        end
    end

    always_comb begin
        if (sel == CFG_PAUSE) rdata = pack_word(pause_lvl);
        else                  rdata = pack_word(drop_lvl);
    end

endmodule

// File: rtl/adm_limit_select.sv
module adm_limit_select
    import buf_adm_pkg::*;
#(
    parameter int NUM_PORTS  = 3,
    parameter int CNT_W      = 8,
    parameter int ACT_THRESH = 36,
    localparam int ACT_W     = $clog2(NUM_PORTS + 1)
) (
    input  logic [CNT_W-1:0] cnt_all [NUM_PORTS],
    input  lvl_pair_t        drop_lvl,
    input  lvl_pair_t        pause_lvl,
    output logic [LVL_W-1:0] drop_lim,
    output logic [LVL_W-1:0] pause_lim,
    output logic [ACT_W-1:0] busy_cnt
);

    logic busy_many;

    always_comb begin
        busy_cnt = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (cnt_all[i] >= CNT_W'(ACT_THRESH)) busy_cnt = busy_cnt + ACT_W'(1);
        end
    end

    assign busy_many = (busy_cnt >= ACT_W'(2));
    assign drop_lim  = pick_level(drop_lvl, busy_many);
    assign pause_lim = pick_level(pause_lvl, busy_many);

endmodule

// File: rtl/adm_port_counter.sv
module adm_port_counter
    import buf_adm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  logic             free,
    input  logic [LVL_W-1:0] drop_lim,
    input  logic [LVL_W-1:0] pause_lim,
    output logic             grant,
    output logic             drop,
    output logic             pause,
    output logic [CNT_W-1:0] cnt
);

    logic room, inc, dec;

    assign room  = (CNT_W'(drop_lim) > cnt) && (cnt != '1);
    assign grant = alloc & room;
    assign drop  = alloc & ~room;
    assign inc   = grant;
    assign dec   = free & (cnt != '0);
    assign pause = (cnt >= CNT_W'(pause_lim));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/buf_admit_ctrl.sv
module buf_admit_ctrl
    import buf_adm_pkg::*;
#(
    parameter int NUM_PORTS  = 3,
    parameter int CNT_W      = 8,
    parameter int ACT_THRESH = 36,
    localparam int ACT_W     = $clog2(NUM_PORTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] alloc_req,
    input  logic [NUM_PORTS-1:0] free_req,
    output logic [NUM_PORTS-1:0] alloc_grant,
    output logic [NUM_PORTS-1:0] alloc_drop,
    output logic [NUM_PORTS-1:0] pause_req,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata
);

    lvl_pair_t        drop_lvl, pause_lvl;
    logic [LVL_W-1:0] drop_lim, pause_lim;
    logic [ACT_W-1:0] busy_cnt;
    logic [CNT_W-1:0] cnt_all [NUM_PORTS];

    adm_cfg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .drop_lvl  (drop_lvl),
        .pause_lvl (pause_lvl),
        .rdata     (cfg_rdata)
    );

    adm_limit_select #(
        .NUM_PORTS  (NUM_PORTS),
        .CNT_W      (CNT_W),
        .ACT_THRESH (ACT_THRESH)
    ) u_sel (
        .cnt_all   (cnt_all),
        .drop_lvl  (drop_lvl),
        .pause_lvl (pause_lvl),
        .drop_lim  (drop_lim),
        .pause_lim (pause_lim),
        .busy_cnt  (busy_cnt)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        adm_port_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .alloc     (alloc_req[g]),
            .free      (free_req[g]),
            .drop_lim  (drop_lim),
            .pause_lim (pause_lim),
            .grant     (alloc_grant[g]),
            .drop      (alloc_drop[g]),
            .pause     (pause_req[g]),
            .cnt       (cnt_all[g])
        );
    end

endmodule

// File: rtl/buf_admit_chk.sv
module buf_admit_chk #(
    parameter int NUM_PORTS = 3,
    parameter int CNT_W     = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] alloc_req,
    input logic [NUM_PORTS-1:0] alloc_grant,
    input logic [NUM_PORTS-1:0] alloc_drop,
    input logic [CNT_W-1:0]     cnt_all [NUM_PORTS]
);

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
        assert_grant_drop_excl_R3: assert property (@(posedge clk) disable iff (rst)
            alloc_req[i] |-> (alloc_grant[i] ^ alloc_drop[i]));

        assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
            !alloc_req[i] |-> !(alloc_grant[i] || alloc_drop[i]));

        assert_unit_step_R1: assert property (@(posedge clk) disable iff (rst)
            (cnt_all[i] == $past(cnt_all[i])) ||
            (cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1)) ||
            (cnt_all[i] == $past(cnt_all[i]) - CNT_W'(1)));

        assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(cnt_all[i]) == '0 && cnt_all[i] != '0) |-> $past(alloc_grant[i]));

        assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(cnt_all[i]) == '1) |-> (cnt_all[i] != '0));
    end

endmodule

bind buf_admit_ctrl buf_admit_chk #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_req   (alloc_req),
    .alloc_grant (alloc_grant),
    .alloc_drop  (alloc_drop),
    .cnt_all     (cnt_all)
);

// File: tb/buf_admit_ctrl_test.sv
module buf_admit_ctrl_test;

    localparam int NP     = 3;
    localparam int THRESH = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] alloc_req = '0, free_req = '0;
    logic [NP-1:0] alloc_grant, alloc_drop, pause_req;
    logic          cfg_wr_en = 1'b0, cfg_addr = 1'b0;
    logic [31:0]   cfg_wdata = '0, cfg_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int mcnt [NP];
    int m_drop_c, m_drop_s, m_pause_c, m_pause_s;

    always #4 clk = ~clk;

    buf_admit_ctrl uut (
        .clk(clk), .rst(rst), .alloc_req(alloc_req), .free_req(free_req),
        .alloc_grant(alloc_grant), .alloc_drop(alloc_drop), .pause_req(pause_req),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata)
    );

    // {write, addr, wdata, expected read-back}
    localparam logic [65:0] CFG_VEC [6] = '{
        {1'b1, 1'b0, 32'hFFFF_1020, 32'h0000_1020},
        {1'b1, 1'b1, 32'hABCD_0810, 32'h0000_0810},
        {1'b0, 1'b0, 32'h0000_0000, 32'h0000_1020},
        {1'b1, 1'b0, 32'h0000_4964, 32'h0000_4964},
        {1'b1, 1'b1, 32'h0000_213C, 32'h0000_213C},
        {1'b0, 1'b1, 32'h0000_0000, 32'h0000_213C}
    };

    task automatic model_reset();
        for (int p = 0; p < NP; p++) mcnt[p] = 0;
        m_drop_c = 'h49; m_drop_s = 'h64; m_pause_c = 'h21; m_pause_s = 'h3C;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic cfg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (a) begin m_pause_c = int'(d[15:8]); m_pause_s = int'(d[7:0]); end
        else   begin m_drop_c  = int'(d[15:8]); m_drop_s  = int'(d[7:0]); end
    endtask

    task automatic cfg_check(input logic a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s cfg addr %0d: actual=%h expected=%h", tag, a, cfg_rdata, exp);
        end
    endtask

    task automatic step(input logic [NP-1:0] a, input logic [NP-1:0] f, input string tag);
        int busy, dl, pl;
        logic eg, ed, ep;
        @(negedge clk);
        alloc_req = a; free_req = f;
        busy = 0;
        for (int p = 0; p < NP; p++) if (mcnt[p] >= THRESH) busy++;
        dl = (busy >= 2) ? m_drop_c  : m_drop_s;
        pl = (busy >= 2) ? m_pause_c : m_pause_s;
        #1;
        for (int p = 0; p < NP; p++) begin
            eg = a[p] && (mcnt[p] < dl) && (mcnt[p] < 255);
            ed = a[p] && !eg;
            ep = (mcnt[p] >= pl);
            checks++;
            if (alloc_grant[p] !== eg || alloc_drop[p] !== ed) begin
                errors++;
                $display("FAIL %s port%0d grant/drop: actual=%b/%b expected=%b/%b (count %0d)",
                         tag, p, alloc_grant[p], alloc_drop[p], eg, ed, mcnt[p]);
            end
            checks++;
            if (pause_req[p] !== ep) begin
                errors++;
                $display("FAIL %s port%0d pause: actual=%b expected=%b (count %0d)",
                         tag, p, pause_req[p], ep, mcnt[p]);
            end
        end
        for (int p = 0; p < NP; p++) begin
            eg = a[p] && (mcnt[p] < dl) && (mcnt[p] < 255);
            if (eg && !(f[p] && mcnt[p] > 0)) mcnt[p]++;
            else if (!eg && f[p] && mcnt[p] > 0) mcnt[p]--;
        end
        @(posedge clk);
        #1;
        alloc_req = '0; free_req = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R3: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R6: reset values and quiet outputs
        cfg_check(1'b0, 32'h0000_4964, "R6");
        cfg_check(1'b1, 32'h0000_213C, "R6");
        step('0, '0, "R6");

        // R5: register table
        for (int i = 0; i < 6; i++) begin
            if (CFG_VEC[i][65]) cfg_write(CFG_VEC[i][64], CFG_VEC[i][63:32]);
            cfg_check(CFG_VEC[i][64], CFG_VEC[i][31:0], "R5");
        end

        // R3 R4: one busy port runs into single-port limits (pause 60, drop 100)
        for (int i = 0; i < 102; i++) step(3'b001, '0, "R3");

        // R7 and R1: free at zero ignored, then alloc+free together
        step('0, 3'b100, "R7");
        step(3'b100, '0, "R7");
        step(3'b100, 3'b100, "R1");
        step('0, 3'b100, "R1");
        step('0, 3'b100, "R7");

        // R2: second port crosses 36, crowded limits (drop 73, pause 33)
        for (int i = 0; i < 40; i++) step(3'b011, '0, "R2");
        for (int i = 0; i < 30; i++) step('0, 3'b001, "R2");
        for (int i = 0; i < 5; i++)  step(3'b001, '0, "R2");
        for (int i = 0; i < 40; i++) step('0, 3'b010, "R2");
        step(3'b001, '0, "R2");

        // R6: mid-run reset clears counts and words
        do_reset();
        cfg_check(1'b0, 32'h0000_4964, "R6");
        step('0, '0, "R6");

        // R2: no port busy uses the single-port thresholds
        cfg_write(1'b1, 32'h0000_0201);
        step(3'b001, '0, "R2");
        step('0, '0, "R2");
        step(3'b001, '0, "R2");

        // R7: saturation at 255
        cfg_write(1'b0, 32'h0000_FFFF);
        cfg_write(1'b1, 32'h0000_FFFF);
        for (int i = 0; i < 258; i++) step(3'b100, '0, "R7");
        step(3'b100, 3'b100, "R7");
        step('0, '0, "R7");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule